// File: doc/BRIEF.md
# Buffered PWM Channel Generator

A single timer channel that produces a pulse-width and frequency modulated waveform from its own up-counter. The counter advances once per prescaler tick and runs from 1 up to an active period value, then reloads to 1. A duty value sets where the edge to the polarity level falls inside each period. The period boundary drives the output to the opposite level.

Duty and period are written into holding registers. They reach the active comparators only at the clock on which the counter reloads to 1, so software may update them at any time without tearing a period. While the channel is disabled, the holding registers feed the comparators directly and the counter may be preset. The output transition is registered: it follows one system clock after the counter leaves the matching count. Constant outputs at either level are available through reserved duty settings.

Top module: `pwm_buffered_chan`

## Requirements
- R1: While enabled, the counter counts up from 1. On the tick that ends a count equal to the active period, it reloads to 1.
- R2: With a divider setting of D, the counter advances exactly once every D+1 system clocks.
- R3: The end of the count equal to the active duty drives the output to `pol`. The end of the count equal to the active period drives it to the complement of `pol`. When both end on the same count, the period action wins. A duty larger than the period never acts, so the output stays at the complement of `pol`.
- R4: The output changes on the second clock edge after the counter leaves the matching count. At the first sample after that count it still shows the old level. For a nonzero duty A below a period B, the output spends A*(D+1) clocks at the complement of `pol` and (B-A)*(D+1) clocks at `pol` in each period.
- R5: A duty value of 0 makes the boundary action drive `pol`, so the output stays at `pol` in every period.
- R6: Writes to duty or period made while enabled take effect only at the next reload to 1. A period value shorter than the current count is not acted on early.
- R7: While `run_en` is low, the output takes the value of `pol` one clock later and the counter holds. `cnt_ld` loads `cnt_ld_val` into the counter only while `run_en` is low, and is ignored while it is high.
- R8: If the counter is above the active period when it is enabled, it counts up to the all-ones value, then moves to 1 and resumes normal operation.
- R9: After reset the counter reads 1 and the output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Channel mode enable |
| pol | input | 1 | Output polarity level driven at the duty edge |
| div_sel | input | DIV_W | Prescaler setting; ratio is div_sel+1 |
| duty_wr | input | 1 | Write strobe for the duty holding register |
| duty_val | input | CNT_W | Duty value to write |
| per_wr | input | 1 | Write strobe for the period holding register |
| per_val | input | CNT_W | Period value to write (must be 2 or more) |
| cnt_ld | input | 1 | Counter preset strobe, honoured only while disabled |
| cnt_ld_val | input | CNT_W | Counter preset value |
| cnt_out | output | CNT_W | Current counter value |
| pwm_out | output | 1 | Waveform output |

## Verification
The assertions assume that the period value is always at least 2 and that `div_sel` stays unchanged while the channel runs. Under those conditions a reload and a tick are well defined. The bench writes only periods of 2 or more and changes the divider, polarity and presets only while `run_en` is low. The duty and period strobes are the only inputs it toggles mid-run. For the constant-output cases, the bench lets one full period pass after enabling before it judges the level, because the level loaded at entry is legitimately overwritten at the first boundary.

// File: rtl/pwm_buffered_chan.sv
module pwm_buffered_chan #(
  parameter int CNT_W   = 24,
  parameter int DIV_W   = 8,
  parameter int PER_RST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             pol,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] duty_val,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_val,
  input  logic             cnt_ld,
  input  logic [CNT_W-1:0] cnt_ld_val,
  output logic [CNT_W-1:0] cnt_out,
  output logic             pwm_out
);

  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] PER_INIT = CNT_W'(PER_RST);

  logic [DIV_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, a_buf, b_buf, a_act, b_act;
  logic             evt_vld, evt_lvl, pwm_q;

  wire tick   = run_en && (pre_q >= div_sel);
  wire hit_a  = (cnt_q == a_act) && (a_act != CNT_ZERO);
  wire hit_b  = (cnt_q == b_act);
  wire at_max = (cnt_q == CNT_MAX);
  wire commit = !run_en || (tick && hit_b);

  assign cnt_out = cnt_q;
  assign pwm_out = pwm_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pre_q <= '0;
    else if (!run_en || tick)  pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_buf <= CNT_ZERO;
      b_buf <= PER_INIT;
    end else begin
      if (duty_wr) a_buf <= duty_val;
      if (per_wr)  b_buf <= per_val;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_act <= CNT_ZERO;
      b_act <= PER_INIT;
    end else if (commit) begin
      a_act <= a_buf;
      b_act <= b_buf;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cnt_q <= CNT_ONE;
    else if (!run_en) begin
      if (cnt_ld)               cnt_q <= cnt_ld_val;
    end else if (tick)          cnt_q <= (hit_b || at_max) ? CNT_ONE : cnt_q + CNT_ONE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      evt_vld <= 1'b0;
      evt_lvl <= 1'b0;
    end else if (tick && hit_b) begin
      evt_vld <= 1'b1;
      evt_lvl <= (a_buf == CNT_ZERO) ? pol : !pol;
    end else if (tick && hit_a) begin
      evt_vld <= 1'b1;
      evt_lvl <= pol;
    end else begin
      evt_vld <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pwm_q <= 1'b0;
    else if (!run_en)  pwm_q <= pol;
    else if (evt_vld)  pwm_q <= evt_lvl;

  assert_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick && hit_b) |=> (cnt_q == CNT_ONE));

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !tick) |=> $stable(cnt_q));

  assert_edge_from_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en) && !$stable(pwm_q)) |-> $past(evt_vld));

  assert_disabled_follows_pol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (pwm_q == $past(pol)));

  assert_wrap_to_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_max) |=> (cnt_q == CNT_ONE));

  assert_buffer_only_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en) && !$stable(b_act)) |-> $past(tick && hit_b));

endmodule

// File: tb/pwm_buffered_chan_test.sv
module pwm_buffered_chan_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 24;
  localparam int DW = 8;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic clk = 0, rst_n = 0, run_en = 0, pol = 0;
  logic [DW-1:0] div_sel = '0;
  logic duty_wr = 0, per_wr = 0, cnt_ld = 0;
  logic [CW-1:0] duty_val = '0, per_val = '0, cnt_ld_val = '0;
  logic [CW-1:0] cnt_out;
  logic pwm_out;
  int checks = 0, failures = 0;
  bit done = 0;

  pwm_buffered_chan #(.CNT_W(CW), .DIV_W(DW), .PER_RST(2)) uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pol(pol), .div_sel(div_sel),
    .duty_wr(duty_wr), .duty_val(duty_val), .per_wr(per_wr), .per_val(per_val),
    .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val), .cnt_out(cnt_out), .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cnt(input logic [CW-1:0] v, input string req);
    int n = 0;
    while (cnt_out != v && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk({req, " timeout waiting for count"}, cnt_out, v);
  endtask

  task automatic setup(input logic [CW-1:0] a, input logic [CW-1:0] b,
                       input logic [DW-1:0] d, input logic p, input logic [CW-1:0] start);
    @(negedge clk);
    run_en = 0; pol = p; div_sel = d;
    duty_wr = 1; duty_val = a; per_wr = 1; per_val = b;
    cnt_ld = 1; cnt_ld_val = start;
    @(negedge clk);
    duty_wr = 0; per_wr = 0; cnt_ld = 0;
    @(negedge clk);
    run_en = 1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 counter after reset", cnt_out, 1);
    chk("R9 output after reset", pwm_out, 0);
  endtask

  task automatic t_wave(input logic [CW-1:0] a, input logic [CW-1:0] b,
                        input logic [DW-1:0] d, input logic p);
    int r = d + 1;
    int n;
    setup(a, b, d, p, 1);
    wait_cnt(b, "R1");
    while (cnt_out == b) @(negedge clk);
    chk("R1 reload after period count", cnt_out, 1);
    wait_cnt(a + 1, "R4");
    chk("R4 output not yet changed", pwm_out, !p);
    @(negedge clk);
    chk("R4 output changed one clock later", pwm_out, p);
    n = 0;
    while (pwm_out == p && n < 5000) begin n++; @(negedge clk); end
    chk("R3 time at pol level", n, (b - a) * r);
    n = 0;
    while (pwm_out == !p && n < 5000) begin n++; @(negedge clk); end
    chk("R3 time at complement level", n, a * r);
  endtask

  task automatic t_prescale;
    int n = 0;
    setup(3, 9, 2, 1, 1);
    wait_cnt(2, "R2");
    while (cnt_out == 2 && n < 100) begin n++; @(negedge clk); end
    chk("R2 clocks per count with ratio 3", n, 3);
  endtask

  task automatic t_const(input logic [CW-1:0] a, input logic [CW-1:0] b,
                         input logic p, input logic exp_lvl, input string req);
    int bad = 0;
    setup(a, b, 0, p, 1);
    wait_cnt(b, req);
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 3 * b; i++) begin
      if (pwm_out != exp_lvl) bad++;
      @(negedge clk);
    end
    chk({req, " constant level mismatches"}, bad, 0);
    chk({req, " level"}, pwm_out, exp_lvl);
  endtask

  task automatic t_buffer;
    setup(3, 12, 0, 1, 1);
    wait_cnt(8, "R6");
    duty_wr = 1; duty_val = 2; per_wr = 1; per_val = 6;
    @(negedge clk);
    duty_wr = 0; per_wr = 0;
    chk("R6 counter keeps old period", cnt_out, 9);
    wait_cnt(12, "R6");
    @(negedge clk);
    chk("R6 reload at old period", cnt_out, 1);
    wait_cnt(6, "R6");
    @(negedge clk);
    chk("R6 new period active next cycle", cnt_out, 1);
    wait_cnt(3, "R6");
    chk("R6 new duty: output still old", pwm_out, 0);
    @(negedge clk);
    chk("R6 new duty: output changed", pwm_out, 1);
  endtask

  task automatic t_disable;
    logic [CW-1:0] held;
    setup(3, 10, 0, 1, 1);
    wait_cnt(5, "R7");
    run_en = 0; pol = 0;
    @(negedge clk);
    chk("R7 output follows pol when disabled", pwm_out, 0);
    held = cnt_out;
    repeat (5) @(negedge clk);
    chk("R7 counter holds when disabled", cnt_out, held);
    pol = 1;
    @(negedge clk);
    chk("R7 output loads pol for entry", pwm_out, 1);
    cnt_ld = 1; cnt_ld_val = 7;
    @(negedge clk);
    cnt_ld = 0;
    chk("R7 preset while disabled", cnt_out, 7);
    run_en = 1; cnt_ld = 1; cnt_ld_val = 3;
    @(negedge clk);
    cnt_ld = 0;
    chk("R7 preset ignored while enabled", cnt_out, 8);
    chk("R7 output holds pol after entry", pwm_out, 1);
  endtask

  task automatic t_wrap;
    setup(2, 5, 0, 1, MAXV - 2);
    chk("R8 counts past period", cnt_out, MAXV - 1);
    @(negedge clk);
    chk("R8 reaches all ones", cnt_out, MAXV);
    @(negedge clk);
    chk("R8 wraps to one", cnt_out, 1);
    wait_cnt(5, "R8");
    @(negedge clk);
    chk("R8 normal reload resumes", cnt_out, 1);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_wave(4, 10, 0, 1);
    t_wave(3, 8, 0, 0);
    t_wave(2, 6, 1, 1);
    t_prescale;
    t_const(0, 5, 1, 1, "R5 zero duty");
    t_const(7, 5, 1, 0, "R3 duty above period");
    t_const(5, 5, 0, 1, "R3 duty equals period");
    t_buffer;
    t_disable;
    t_wrap;
    done = 1;
    finish_run;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      finish_run;
    end
  end
endmodule